// File: doc/BRIEF.md
# Chip-Selected Static Word Memory with Releasable Output

This block is a small static memory of 16 words of 4 bits each. A select input gates a one-hot row decoder, so only a selected device can capture data or put a word on its output. A stored word is read combinationally from the current address. The output pins are released to high impedance unless the device is selected, output enable is active and no write is requested. Because of this, several devices can hang on one shared data bus.

Depth can be doubled without any extra logic inside the block. Two instances share the address, data and control lines. A fifth address bit drives the select of the upper device directly and, through an inverter, the select of the lower device. The bench wires up exactly this 32-word pair on a pull-down bus. Address and data widths are parameters, and the depth follows from the address width.

Top module: `csram_word_array`

## Requirements
- R1: While `rst_n` is low, every word is cleared to zero, and reads after reset return zero until the word is written.
- R2: The row decoder asserts exactly the row equal to `addr` while `cs` is high, and asserts no row while `cs` is low.
- R3: When `cs` and `we` are both high at a rising edge of `clk`, `din` is stored in the word at `addr`, and every other word keeps its value.
- R4: When `cs` is low at a rising edge, no word changes, whatever `we` and `din` hold.
- R5: With `cs` high, `oe` high and `we` low, `dout` shows the word at the current `addr` in the same cycle, without waiting for a clock edge.
- R6: With `cs` low, all bits of `dout` are high impedance (`z`).
- R7: With `oe` low, all bits of `dout` are high impedance, even while `cs` is high.
- R8: With `we` high, all bits of `dout` are high impedance, so the device never drives the bus in a cycle where it stores data.
- R9: In a pair of devices on a shared bus, where address bit 4 drives the upper device's `cs` and its inverse drives the lower device's `cs`, exactly the addressed device drives a read. The bus therefore carries that device's word with no contention, and carries the pull-down value zero when neither device drives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes are taken on its rising edge |
| rst_n | input | 1 | Active-low asynchronous clear of all words |
| cs | input | 1 | Device select; gates the row decoder and the output |
| we | input | 1 | Write request; also forces the output to release |
| oe | input | 1 | Output enable |
| addr | input | ADDR_W (4) | Word address |
| din | input | DATA_W (4) | Write data |
| dout | output | DATA_W (4) | Read data, high impedance when not driving |

## Verification
A write and a read request can fall in the same cycle: select, write and output enable all high together. The bench provokes this by keeping `oe` high through every write to the pair. It then judges, mid-cycle, that the pull-down bus reads zero. In the following cycle it judges that a read of the same address returns the new word. Every address of the pair holds a pattern whose upper two bits identify its device. A read that two devices drive at once therefore shows a value no single word can hold, which the per-cycle comparison against the reference model catches.

// File: rtl/csram_pkg.sv
package csram_pkg;
  localparam int unsigned CSRAM_ADDR_W = 4;
  localparam int unsigned CSRAM_DATA_W = 4;

  typedef enum logic [1:0] {
    PORT_OFF   = 2'd0,
    PORT_HOLD  = 2'd1,
    PORT_READ  = 2'd2,
    PORT_WRITE = 2'd3
  } port_mode_e;
endpackage

// File: rtl/csram_row_decoder.sv
module csram_row_decoder #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    sel,
  output logic [(1<<ADDR_W)-1:0]  row_sel
);
  localparam int unsigned ROWS = 1 << ADDR_W;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_sel[r] = sel && (addr == ADDR_W'(r));
  end
endmodule

// File: rtl/csram_store.sv
module csram_store #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [(1<<ADDR_W)-1:0]                row_sel,
  input  logic                                  wr,
  input  logic [DATA_W-1:0]                     din,
  output logic [(1<<ADDR_W)-1:0][DATA_W-1:0]    words,
  output logic [DATA_W-1:0]                     rd_data
);
  localparam int unsigned ROWS = 1 << ADDR_W;

  for (genvar r = 0; r < ROWS; r++) begin : g_word
    logic [DATA_W-1:0] cell_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= '0;
      end else if (row_sel[r] && wr) begin
        cell_q <= din;
      end
    end

    assign words[r] = cell_q;
  end

  // AND-OR read path: only the selected row contributes
  always_comb begin
    rd_data = '0;
    for (int r = 0; r < ROWS; r++) begin
      rd_data = rd_data | (row_sel[r] ? words[r] : '0);
    end
  end
endmodule

// File: rtl/csram_bus_gate.sv
module csram_bus_gate
  import csram_pkg::*;
(
  input  logic       cs,
  input  logic       we,
  input  logic       oe,
  output port_mode_e mode,
  output logic       drive_en
);
  always_comb begin
    if (!cs) begin
      mode = PORT_OFF;
    end else if (we) begin
      mode = PORT_WRITE;
    end else if (oe) begin
      mode = PORT_READ;
    end else begin
      mode = PORT_HOLD;
    end
  end

  assign drive_en = (mode == PORT_READ);
endmodule

// File: rtl/csram_word_array.sv
module csram_word_array
  import csram_pkg::*;
#(
  parameter int unsigned ADDR_W = CSRAM_ADDR_W,
  parameter int unsigned DATA_W = CSRAM_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic              oe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output wire  [DATA_W-1:0] dout
);
  localparam int unsigned ROWS = 1 << ADDR_W;

  logic [ROWS-1:0]              row_sel;
  logic [ROWS-1:0][DATA_W-1:0]  words;
  logic [DATA_W-1:0]            rd_data;
  logic                         drive_en;
  port_mode_e                   mode;

  csram_row_decoder #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (addr),
    .sel     (cs),
    .row_sel (row_sel)
  );

  csram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .row_sel (row_sel),
    .wr      (we),
    .din     (din),
    .words   (words),
    .rd_data (rd_data)
  );

  csram_bus_gate u_gate (
    .cs       (cs),
    .we       (we),
    .oe       (oe),
    .mode     (mode),
    .drive_en (drive_en)
  );

  assign dout = drive_en ? rd_data : {DATA_W{1'bz}};
endmodule

// File: rtl/csram_word_array_chk.sv
module csram_word_array_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 4
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                cs,
  input logic                                we,
  input logic                                oe,
  input logic [ADDR_W-1:0]                   addr,
  input logic [DATA_W-1:0]                   din,
  input logic [(1<<ADDR_W)-1:0]              row_sel,
  input logic [(1<<ADDR_W)-1:0][DATA_W-1:0]  words,
  input logic [DATA_W-1:0]                   rd_data,
  input logic                                drive_en
);
  // R2
  one_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs |-> $countones(row_sel) == 1);

  // R2
  idle_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> row_sel == '0);

  // R2
  row_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs |-> row_sel[addr]);

  // R3
  write_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we) |=> words[$past(addr)] == $past(din));

  // R4
  no_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> $stable(words));

  // R5
  read_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && oe && !we) |-> (drive_en && rd_data == words[addr]));

  // R6
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !drive_en);

  // R7
  quiet_noe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !drive_en);

  // R8
  quiet_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !drive_en);
endmodule

bind csram_word_array csram_word_array_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs       (cs),
  .we       (we),
  .oe       (oe),
  .addr     (addr),
  .din      (din),
  .row_sel  (row_sel),
  .words    (words),
  .rd_data  (rd_data),
  .drive_en (drive_en)
);

// File: tb/csram_word_array_bench.sv
module csram_word_array_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       we = 1'b0;
  logic       oe = 1'b0;
  logic [4:0] a = '0;
  logic [3:0] din = '0;
  wire  [3:0] bus;
  logic       cs_lo;
  logic       cs_hi;

  int errors = 0;
  int checks = 0;
  logic [3:0] model [32];

  always #10 clk = ~clk;

  assign cs_hi = en & a[4];
  assign cs_lo = en & ~a[4];

  for (genvar b = 0; b < 4; b++) begin : g_pd
    pulldown (bus[b]);
  end

  csram_word_array u_csram_word_array (
    .clk (clk), .rst_n (rst_n), .cs (cs_lo), .we (we), .oe (oe),
    .addr (a[3:0]), .din (din), .dout (bus)
  );

  csram_word_array u_csram_word_array_hi (
    .clk (clk), .rst_n (rst_n), .cs (cs_hi), .we (we), .oe (oe),
    .addr (a[3:0]), .din (din), .dout (bus)
  );

  task automatic check(input logic [3:0] got, input logic [3:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: addr=%0d bus=%h expected=%h", req, a, got, exp);
    end
  endtask

  // one bus cycle: drive at negedge, judge mid low phase, update model at edge
  task automatic cyc(input logic e, input logic [4:0] ad, input logic w,
                     input logic o, input logic [3:0] d, input string req);
    logic [3:0] exp;
    @(negedge clk);
    en = e; a = ad; we = w; oe = o; din = d;
    #5;
    exp = (e && o && !w) ? model[ad] : 4'h0;
    check(bus, exp, req);
    @(posedge clk);
    if (e && w) model[ad] = d;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    en = 1'b1; oe = 1'b1; we = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = 4'h0;
    #5;
    check(bus, 4'h0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [3:0] pat(input int i);
    return (i >= 16) ? {2'b10, 2'(i)} : {2'b01, 2'(i)};
  endfunction

  initial begin
    #(20 * 5000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1: every word reads zero after reset
    for (int i = 0; i < 32; i++) cyc(1, 5'(i), 0, 1, 4'h0, "R1");
    // R3 R8: fill both devices with oe held high during writes
    for (int i = 0; i < 32; i++) cyc(1, 5'(i), 1, 1, pat(i), "R8");
    // R5 R9: read back every address from the shared bus
    for (int i = 0; i < 32; i++) cyc(1, 5'(i), 0, 1, 4'hF, "R9");
    // R4 R6: deselected writes change nothing and release the bus
    cyc(0, 5'd3, 1, 1, 4'hF, "R6");
    cyc(0, 5'd20, 1, 1, 4'hF, "R4");
    cyc(0, 5'd9, 0, 1, 4'h0, "R6");
    cyc(1, 5'd3, 0, 1, 4'h0, "R4");
    cyc(1, 5'd20, 0, 1, 4'h0, "R4");
    // R7: output enable low releases a selected device
    cyc(1, 5'd7, 0, 0, 4'h0, "R7");
    cyc(1, 5'd23, 0, 0, 4'h0, "R7");
    // R3: overwrite one word, neighbours untouched, read next cycle
    cyc(1, 5'd5, 1, 1, 4'hA, "R8");
    cyc(1, 5'd5, 0, 1, 4'h0, "R3");
    cyc(1, 5'd4, 0, 1, 4'h0, "R3");
    cyc(1, 5'd6, 0, 1, 4'h0, "R3");
    cyc(1, 5'd21, 0, 1, 4'h0, "R3");
    // R2 R9: same low address bits, both halves, alternating
    for (int i = 0; i < 8; i++) cyc(1, (i % 2 == 1) ? 5'd18 : 5'd2, 0, 1, 4'h0, "R2");
    // R9: mixed random traffic judged against the model every cycle
    for (int i = 0; i < 300; i++)
      cyc(1'($urandom_range(0, 3) != 0), 5'($urandom), 1'($urandom_range(0, 3) == 0),
          1'($urandom_range(0, 4) != 0), 4'($urandom), "R9");
    // R1: reset in mid-run clears stored words
    do_reset();
    cyc(1, 5'd5, 0, 1, 4'h0, "R1");
    cyc(1, 5'd29, 0, 1, 4'h0, "R1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule